// File: doc/BRIEF.md
# Dataless-way-aware cache set controller

This block holds the tag, state and data arrays of a small set-associative last-level cache in which some ways have no data storage. The two lowest ways of every set are built with tag and dirty state only. A run-time count switches off a further group of data ways, and those ways then act as tag-only ways too. The block accepts one request per cycle on a single port. A request is a fill from memory, a writeback from a private cache, or a lookup. It answers every accepted request one cycle later.

Fills are steered by their coherence state. A block that a private cache will own goes to a free tag-only way. A shared block goes to a data way first and uses a tag-only way only when no data way is free. A writeback that hits a tag-only way moves the block into a data way of the same set and frees the old tag entry. When the destination data way is taken, the least recently used data block is evicted, and a dirty victim goes out on the memory writeback port. Raising the disable count walks every set of each newly disabled way, one entry per cycle. It writes dirty blocks back to memory and invalidates the ways before they become tag-only. Requests stall while this walk runs.

Top module: `dataless_set_ctrl`

## Requirements
- R1: After reset every entry is invalid, so lookups miss, the disable count is zero, `req_ready` is 1, and `rsp_valid` and `mem_wb_valid` are 0.
- R2: Ways 0 and 1 are always tag-only. With disable count N, ways 2 to 2+N-1 are also tag-only, and the rest carry data. N is clamped to 13, so way 15 always carries data.
- R3: A fill with `req_excl`=1 goes to the lowest-numbered invalid tag-only way, with `rsp_present`=0. When no tag-only way is free, it goes to a data way with `rsp_present`=1.
- R4: A fill with `req_excl`=0 goes to the lowest-numbered invalid data way. When no data way is free, it falls back to the lowest invalid tag-only way (`rsp_present`=0).
- R5: A lookup hitting a data way returns `rsp_hit`=1, `rsp_present`=1 and the stored data. A hit on a tag-only way returns `rsp_hit`=1, `rsp_present`=0 and data 0. A miss returns `rsp_hit`=0 and way 0.
- R6: A writeback hitting a data way replaces that way's data, marks it dirty, and reports that way.
- R7: A writeback hitting a tag-only way moves the block to the lowest invalid data way, or to the LRU data way when all are valid. It reports the destination, and later lookups find the new data there. The old tag-only entry is free for the next fill.
- R8: When a data way must be taken and none is invalid, the victim is the least recently used valid data way. A dirty victim appears on `mem_wb_*` with its own address and data in the response cycle, and a clean victim produces no memory writeback.
- R9: A writeback that misses is forwarded unchanged to `mem_wb_*` in the response cycle, with `rsp_hit`=0.
- R10: On an increase of the disable count, `req_ready` falls. Each newly disabled way is invalidated set by set, one entry per cycle, and each dirty entry is written to memory. On a decrease, the re-enabled ways are invalidated with no memory writeback.
- R11: Recency is updated on every fill, writeback and lookup hit. A way just touched becomes the most recent in its set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Requests accepted (low while a disable walk runs) |
| req_op | input | 2 | 1 fill, 2 writeback, 3 lookup |
| req_addr | input | 12 | Block address; low 2 bits select the set |
| req_excl | input | 1 | Fill state: 1 exclusive (owned privately), 0 shared |
| req_data | input | 32 | Fill or writeback data |
| dis_req | input | 4 | Requested number of disabled data ways |
| rsp_valid | output | 1 | Response for the request accepted last cycle |
| rsp_hit | output | 1 | Tag matched |
| rsp_present | output | 1 | Block sits in a data-bearing way |
| rsp_way | output | 4 | Way hit or written |
| rsp_data | output | 32 | Lookup data when present, else 0 |
| mem_wb_valid | output | 1 | Writeback to memory |
| mem_wb_addr | output | 12 | Writeback address |
| mem_wb_data | output | 32 | Writeback data |

## Verification
The assertions rely on two facts about the inputs. No fill is issued for an address already held in its set, so at most one tag ever matches. Requests come only while `req_ready` is high. The stimulus keeps to this by filling only fresh tags in each set, and it changes the disable count only when the block is idle. It then waits for `req_ready` to return before it issues the next request. The memory writebacks during each disable walk are counted and compared against the dirty blocks that the earlier writebacks left in the affected ways.

// File: rtl/dlc_pkg.sv
package dlc_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_FILL = 2'd1,
        OP_WB   = 2'd2,
        OP_LOOK = 2'd3
    } op_e;

    // clamp a requested disable count so that one data way always remains
    function automatic int clamp_dis(input int req, input int max_dis);
        return (req > max_dis) ? max_dis : req;
    endfunction

endpackage

// File: rtl/dlc_way_pick.sv
module dlc_way_pick #(
    parameter int NW    = 16,
    parameter int WAY_W = 4,
    parameter int AGE_W = 4
) (
    input  logic [NW-1:0]       cand,
    input  logic [NW-1:0]       valid,
    input  logic [NW*AGE_W-1:0] ages,
    output logic                free_found,
    output logic [WAY_W-1:0]    free_way,
    output logic [WAY_W-1:0]    old_way
);
    logic [AGE_W-1:0] best_age;
    logic             seen;

    // lowest-numbered invalid candidate
    always_comb begin
        free_found = 1'b0;
        free_way   = '0;
        for (int w = NW - 1; w >= 0; w--) begin
            if (cand[w] && !valid[w]) begin
                free_found = 1'b1;
                free_way   = WAY_W'(w);
            end
        end
    end

    // oldest candidate (largest age)
    always_comb begin
        best_age = '0;
        seen     = 1'b0;
        old_way  = '0;
        for (int w = 0; w < NW; w++) begin
            if (cand[w] && (!seen || ages[w*AGE_W +: AGE_W] > best_age)) begin
                seen     = 1'b1;
                best_age = ages[w*AGE_W +: AGE_W];
                old_way  = WAY_W'(w);
            end
        end
    end

endmodule

// File: rtl/dlc_dis_seq.sv
module dlc_dis_seq
    import dlc_pkg::*;
#(
    parameter int SETS   = 4,
    parameter int IDX_W  = 2,
    parameter int WAY_W  = 4,
    parameter int STATIC = 2,
    parameter int MAXDIS = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WAY_W-1:0] dis_req,
    output logic             busy,
    output logic             up,
    output logic [IDX_W-1:0] scan_set,
    output logic [WAY_W-1:0] scan_way,
    output logic [WAY_W-1:0] dis_cur
);
    logic [WAY_W-1:0] target;

    always_comb begin
        target   = WAY_W'(clamp_dis(int'(dis_req), MAXDIS));
        busy     = (target != dis_cur);
        up       = (target > dis_cur);
        scan_way = WAY_W'(STATIC) + dis_cur - (up ? WAY_W'(0) : WAY_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dis_cur  <= '0;
            scan_set <= '0;
        end else if (busy) begin
            if (scan_set == IDX_W'(SETS - 1)) begin
                scan_set <= '0;
                dis_cur  <= up ? dis_cur + WAY_W'(1) : dis_cur - WAY_W'(1);
            end else begin
                scan_set <= scan_set + IDX_W'(1);
            end
        end
    end

    // R10: the class boundary moves one way at a time
    a_r10_one_step: assert property (@(posedge clk) disable iff (rst)
        !$stable(dis_cur) |->
            (dis_cur == $past(dis_cur) + WAY_W'(1)) || (dis_cur == $past(dis_cur) - WAY_W'(1)));

    // R10: a way changes class only after every set has been walked
    a_r10_full_walk: assert property (@(posedge clk) disable iff (rst)
        !$stable(dis_cur) |-> (scan_set == '0));

endmodule

// File: rtl/dataless_set_ctrl.sv
module dataless_set_ctrl
    import dlc_pkg::*;
#(
    parameter int SETS      = 4,
    parameter int WAYS      = 16,
    parameter int STATIC_TO = 2,
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_excl,
    input  logic [DATA_W-1:0] req_data,
    input  logic [$clog2(WAYS)-1:0] dis_req,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_present,
    output logic [$clog2(WAYS)-1:0] rsp_way,
    output logic [DATA_W-1:0] rsp_data,
    output logic              mem_wb_valid,
    output logic [ADDR_W-1:0] mem_wb_addr,
    output logic [DATA_W-1:0] mem_wb_data
);
    localparam int IDX_W  = $clog2(SETS);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int TAG_W  = ADDR_W - IDX_W;
    localparam int DWAYS  = WAYS - STATIC_TO;
    localparam int MAXDIS = DWAYS - 1;
    localparam int AGE_W  = WAY_W;

    typedef struct packed {
        logic             inst;
        logic [WAY_W-1:0] dest;
        logic             wr_dat;
        logic             dirty;
        logic             free_old;
        logic             evict;
        logic             pass;
        logic             touch;
        logic             r_hit;
        logic             r_pres;
        logic [DATA_W-1:0] r_data;
    } act_t;

    // arrays
    logic [TAG_W-1:0]       tag_q [SETS][WAYS];
    logic [WAYS-1:0]        val_q [SETS];
    logic [WAYS-1:0]        dirty_q [SETS];
    logic [WAYS*AGE_W-1:0]  age_q [SETS];
    logic [DATA_W-1:0]      dat_q [SETS][DWAYS];

    // disable sequencer
    logic             busy, up;
    logic [IDX_W-1:0] scan_set;
    logic [WAY_W-1:0] scan_way, dis_cur;

    dlc_dis_seq #(
        .SETS(SETS), .IDX_W(IDX_W), .WAY_W(WAY_W), .STATIC(STATIC_TO), .MAXDIS(MAXDIS)
    ) u_seq (
        .clk(clk), .rst(rst), .dis_req(dis_req), .busy(busy), .up(up),
        .scan_set(scan_set), .scan_way(scan_way), .dis_cur(dis_cur)
    );

    logic [IDX_W-1:0] set_i;
    logic [TAG_W-1:0] tag_i;
    logic [WAYS-1:0]  to_mask, dmask, match, dirty_to;
    logic             hit, hit_to, accept;
    logic [WAY_W-1:0] hit_way;

    function automatic logic [WAY_W-1:0] didx(input logic [WAY_W-1:0] w);
        return (w >= WAY_W'(STATIC_TO)) ? w - WAY_W'(STATIC_TO) : '0;
    endfunction

    function automatic logic [WAYS*AGE_W-1:0] touch_age(input logic [WAYS*AGE_W-1:0] a,
                                                        input logic [WAY_W-1:0] w);
        logic [WAYS*AGE_W-1:0] r;
        logic [AGE_W-1:0]      ref_age;
        r       = a;
        ref_age = a[int'(w)*AGE_W +: AGE_W];
        for (int v = 0; v < WAYS; v++) begin
            if (a[v*AGE_W +: AGE_W] < ref_age)
                r[v*AGE_W +: AGE_W] = a[v*AGE_W +: AGE_W] + AGE_W'(1);
        end
        r[int'(w)*AGE_W +: AGE_W] = '0;
        return r;
    endfunction

    always_comb begin
        set_i     = req_addr[IDX_W-1:0];
        tag_i     = req_addr[ADDR_W-1:IDX_W];
        accept    = req_valid && !busy;
        req_ready = !busy;
        hit_way   = '0;
        for (int w = 0; w < WAYS; w++) begin
            to_mask[w] = (w < STATIC_TO + int'(dis_cur));
            match[w]   = val_q[set_i][w] && (tag_q[set_i][w] == tag_i);
            if (match[w]) hit_way = WAY_W'(w);
        end
        dmask  = ~to_mask;
        hit    = |match;
        hit_to = |(match & to_mask);
        dirty_to = '0;
        for (int s = 0; s < SETS; s++) dirty_to = dirty_to | (dirty_q[s] & to_mask);
    end

    // victim / free-way selection per class
    logic             to_free, dat_free;
    logic [WAY_W-1:0] to_free_way, to_old_way, dat_free_way, dat_old_way;

    dlc_way_pick #(.NW(WAYS), .WAY_W(WAY_W), .AGE_W(AGE_W)) u_pick_to (
        .cand(to_mask), .valid(val_q[set_i]), .ages(age_q[set_i]),
        .free_found(to_free), .free_way(to_free_way), .old_way(to_old_way)
    );

    dlc_way_pick #(.NW(WAYS), .WAY_W(WAY_W), .AGE_W(AGE_W)) u_pick_dat (
        .cand(dmask), .valid(val_q[set_i]), .ages(age_q[set_i]),
        .free_found(dat_free), .free_way(dat_free_way), .old_way(dat_old_way)
    );

    // tag-only victims are never taken: such blocks are owned by a private cache
    logic unused_pick;
    assign unused_pick = ^to_old_way;

    act_t act;

    always_comb begin
        act = '0;
        case (op_e'(req_op))
            OP_FILL: begin
                act.inst  = 1'b1;
                act.touch = 1'b1;
                if (req_excl && to_free) begin
                    act.dest = to_free_way;
                end else if (!req_excl && dat_free) begin
                    act.dest = dat_free_way;  act.wr_dat = 1'b1;
                end else if (!req_excl && to_free) begin
                    act.dest = to_free_way;
                end else if (dat_free) begin
                    act.dest = dat_free_way;  act.wr_dat = 1'b1;
                end else begin
                    act.dest = dat_old_way;   act.wr_dat = 1'b1;  act.evict = 1'b1;
                end
                act.r_pres = act.wr_dat;
            end
            OP_WB: begin
                if (hit && !hit_to) begin
                    act.inst = 1'b1;  act.dest = hit_way;
                    act.wr_dat = 1'b1;  act.dirty = 1'b1;  act.touch = 1'b1;
                end else if (hit) begin
                    act.inst = 1'b1;  act.wr_dat = 1'b1;  act.dirty = 1'b1;
                    act.touch = 1'b1;  act.free_old = 1'b1;
                    if (dat_free) begin
                        act.dest = dat_free_way;
                    end else begin
                        act.dest = dat_old_way;  act.evict = 1'b1;
                    end
                end else begin
                    act.pass = 1'b1;
                end
                act.r_hit  = hit;
                act.r_pres = hit;
            end
            OP_LOOK: begin
                act.dest   = hit_way;
                act.touch  = hit;
                act.r_hit  = hit;
                act.r_pres = hit && !hit_to;
                act.r_data = (hit && !hit_to) ? dat_q[set_i][didx(hit_way)] : '0;
            end
            default: act = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                val_q[s]   <= '0;
                dirty_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    tag_q[s][w] <= '0;
                    age_q[s][w*AGE_W +: AGE_W] <= AGE_W'(w);
                end
            end
            rsp_valid    <= 1'b0;
            rsp_hit      <= 1'b0;
            rsp_present  <= 1'b0;
            rsp_way      <= '0;
            rsp_data     <= '0;
            mem_wb_valid <= 1'b0;
            mem_wb_addr  <= '0;
            mem_wb_data  <= '0;
        end else begin
            rsp_valid    <= 1'b0;
            mem_wb_valid <= 1'b0;
            if (busy) begin
                if (up && val_q[scan_set][scan_way] && dirty_q[scan_set][scan_way]) begin
                    mem_wb_valid <= 1'b1;
                    mem_wb_addr  <= {tag_q[scan_set][scan_way], scan_set};
                    mem_wb_data  <= dat_q[scan_set][didx(scan_way)];
                end
                val_q[scan_set][scan_way]   <= 1'b0;
                dirty_q[scan_set][scan_way] <= 1'b0;
            end else if (accept && req_op != OP_NONE) begin
                if (act.free_old) begin
                    val_q[set_i][hit_way]   <= 1'b0;
                    dirty_q[set_i][hit_way] <= 1'b0;
                end
                if (act.inst) begin
                    tag_q[set_i][act.dest]   <= tag_i;
                    val_q[set_i][act.dest]   <= 1'b1;
                    dirty_q[set_i][act.dest] <= act.dirty;
                    if (act.wr_dat) dat_q[set_i][didx(act.dest)] <= req_data;
                end
                if (act.evict && dirty_q[set_i][act.dest]) begin
                    mem_wb_valid <= 1'b1;
                    mem_wb_addr  <= {tag_q[set_i][act.dest], set_i};
                    mem_wb_data  <= dat_q[set_i][didx(act.dest)];
                end
                if (act.pass) begin
                    mem_wb_valid <= 1'b1;
                    mem_wb_addr  <= req_addr;
                    mem_wb_data  <= req_data;
                end
                if (act.touch) age_q[set_i] <= touch_age(age_q[set_i], act.dest);
                rsp_valid   <= 1'b1;
                rsp_hit     <= act.r_hit;
                rsp_present <= act.r_pres;
                rsp_way     <= act.dest;
                rsp_data    <= act.r_data;
            end
        end
    end

    // R2: a way in the tag-only class never holds a dirty block
    a_r2_tagonly_clean: assert property (@(posedge clk) disable iff (rst)
        dirty_to == '0);

    // R5: data is reported present only from a data-bearing way
    a_r5_present_in_data: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_present |-> rsp_way >= WAY_W'(STATIC_TO) + dis_cur);

    // R7: tags are unique within a set, so a request matches at most one way
    a_r7_unique_match: assert property (@(posedge clk) disable iff (rst)
        accept |-> $onehot0(match));

    // R10: shrinking the disable count writes nothing to memory
    a_r10_no_wb_down: assert property (@(posedge clk) disable iff (rst)
        busy && !up |=> !mem_wb_valid);

endmodule

// File: tb/sim_dataless_set_ctrl.sv
`timescale 1ns/1ps
module sim_dataless_set_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [11:0] req_addr = '0;
    logic        req_excl = 1'b0;
    logic [31:0] req_data = '0;
    logic [3:0]  dis_req = '0;
    logic        rsp_valid, rsp_hit, rsp_present;
    logic [3:0]  rsp_way;
    logic [31:0] rsp_data;
    logic        mem_wb_valid;
    logic [11:0] mem_wb_addr;
    logic [31:0] mem_wb_data;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dataless_set_ctrl u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_excl(req_excl), .req_data(req_data),
        .dis_req(dis_req), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_present(rsp_present), .rsp_way(rsp_way), .rsp_data(rsp_data),
        .mem_wb_valid(mem_wb_valid), .mem_wb_addr(mem_wb_addr), .mem_wb_data(mem_wb_data)
    );

    localparam logic [1:0] FL = 2'd1, WB = 2'd2, LK = 2'd3;

    typedef struct packed {
        logic [3:0]  rq;
        logic [1:0]  op;
        logic [11:0] addr;
        logic        ex;
        logic [31:0] d;
        logic        hit;
        logic        pres;
        logic [3:0]  way;
        logic [31:0] rd;
        logic        wb;
        logic [11:0] wba;
        logic [31:0] wbd;
    } vec_t;

    // set 0 walk, disable count 0: tag-only ways 0..1
    localparam vec_t TBL [13] = '{
        '{4'd3,  FL, 12'h004, 1'b1, 32'hA000_0001, 1'b0, 1'b0, 4'd0, 32'h0, 1'b0, 12'h0, 32'h0},         // R3 -> way0
        '{4'd3,  FL, 12'h008, 1'b1, 32'hA000_0002, 1'b0, 1'b0, 4'd1, 32'h0, 1'b0, 12'h0, 32'h0},         // R3 -> way1
        '{4'd3,  FL, 12'h00C, 1'b1, 32'hA000_0003, 1'b0, 1'b1, 4'd2, 32'h0, 1'b0, 12'h0, 32'h0},         // R3 fallback
        '{4'd4,  FL, 12'h010, 1'b0, 32'hA000_0004, 1'b0, 1'b1, 4'd3, 32'h0, 1'b0, 12'h0, 32'h0},         // R4
        '{4'd5,  LK, 12'h010, 1'b0, 32'h0,         1'b1, 1'b1, 4'd3, 32'hA000_0004, 1'b0, 12'h0, 32'h0}, // R5 data hit
        '{4'd5,  LK, 12'h004, 1'b0, 32'h0,         1'b1, 1'b0, 4'd0, 32'h0, 1'b0, 12'h0, 32'h0},         // R5 tag-only
        '{4'd5,  LK, 12'h024, 1'b0, 32'h0,         1'b0, 1'b0, 4'd0, 32'h0, 1'b0, 12'h0, 32'h0},         // R5 miss
        '{4'd7,  WB, 12'h004, 1'b0, 32'hB000_0001, 1'b1, 1'b1, 4'd4, 32'h0, 1'b0, 12'h0, 32'h0},         // R7 move
        '{4'd7,  LK, 12'h004, 1'b0, 32'h0,         1'b1, 1'b1, 4'd4, 32'hB000_0001, 1'b0, 12'h0, 32'h0}, // R7 new home
        '{4'd6,  WB, 12'h010, 1'b0, 32'hB000_0004, 1'b1, 1'b1, 4'd3, 32'h0, 1'b0, 12'h0, 32'h0},         // R6
        '{4'd9,  WB, 12'h050, 1'b0, 32'hB000_0020, 1'b0, 1'b0, 4'd0, 32'h0, 1'b1, 12'h050, 32'hB000_0020}, // R9
        '{4'd4,  FL, 12'h014, 1'b0, 32'hA000_0005, 1'b0, 1'b1, 4'd5, 32'h0, 1'b0, 12'h0, 32'h0},         // R4 data first
        '{4'd7,  FL, 12'h018, 1'b1, 32'hA000_0006, 1'b0, 1'b0, 4'd0, 32'h0, 1'b0, 12'h0, 32'h0}          // R7 freed way0
    };

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic do_op(input logic [1:0] o, input logic [11:0] a, input logic ex,
                         input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = o;
        req_addr  = a;
        req_excl  = ex;
        req_data  = d;
        @(posedge clk);
        #2;
        req_valid = 1'b0;
    endtask

    task automatic set_dis(input logic [3:0] n, output int wbs, output logic [11:0] wa,
                           output logic [31:0] wd, output logic rdy0);
        @(negedge clk);
        dis_req = n;
        wbs = 0; wa = '0; wd = '0; rdy0 = 1'b1;
        for (int c = 0; c < 400; c++) begin
            @(posedge clk);
            #2;
            if (c == 0) rdy0 = req_ready;
            if (mem_wb_valid) begin
                wbs++;
                wa = mem_wb_addr;
                wd = mem_wb_data;
            end
            if (req_ready) break;
        end
    endtask

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int          n;
        logic [11:0] wa;
        logic [31:0] wd;
        logic        r0;

        repeat (3) @(posedge clk);
        #2;
        rst = 1'b0;
        // R1: reset state
        chk("R1 ready after reset", 64'(req_ready), 64'd1);
        chk("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
        chk("R1 mem_wb_valid after reset", 64'(mem_wb_valid), 64'd0);
        do_op(LK, 12'h004, 1'b0, 32'h0);
        chk("R1 lookup misses after reset", 64'(rsp_hit), 64'd0);

        for (int i = 0; i < 13; i++) begin
            do_op(TBL[i].op, TBL[i].addr, TBL[i].ex, TBL[i].d);
            chk($sformatf("R%0d vec%0d rsp_valid", TBL[i].rq, i), 64'(rsp_valid), 64'd1);
            chk($sformatf("R%0d vec%0d hit", TBL[i].rq, i), 64'(rsp_hit), 64'(TBL[i].hit));
            chk($sformatf("R%0d vec%0d present", TBL[i].rq, i), 64'(rsp_present), 64'(TBL[i].pres));
            chk($sformatf("R%0d vec%0d way", TBL[i].rq, i), 64'(rsp_way), 64'(TBL[i].way));
            chk($sformatf("R%0d vec%0d data", TBL[i].rq, i), 64'(rsp_data), 64'(TBL[i].rd));
            chk($sformatf("R%0d vec%0d mem_wb", TBL[i].rq, i), 64'(mem_wb_valid), 64'(TBL[i].wb));
            if (TBL[i].wb) begin
                chk($sformatf("R%0d vec%0d wb addr", TBL[i].rq, i), 64'(mem_wb_addr), 64'(TBL[i].wba));
                chk($sformatf("R%0d vec%0d wb data", TBL[i].rq, i), 64'(mem_wb_data), 64'(TBL[i].wbd));
            end
        end

        // R10: disable ways 2,3; set0 way3 holds dirty 0x010
        set_dis(4'd2, n, wa, wd, r0);
        chk("R10 ready low during walk", 64'(r0), 64'd0);
        chk("R10 one writeback on 0->2", 64'(n), 64'd1);
        chk("R10 flushed address", 64'(wa), 64'h010);
        chk("R10 flushed data", 64'(wd), 64'hB000_0004);
        do_op(LK, 12'h00C, 1'b0, 32'h0);
        chk("R10 clean block in disabled way gone", 64'(rsp_hit), 64'd0);
        do_op(LK, 12'h010, 1'b0, 32'h0);
        chk("R10 dirty block in disabled way gone", 64'(rsp_hit), 64'd0);
        do_op(FL, 12'h01C, 1'b0, 32'hA000_0007);
        chk("R4 shared fill skips disabled ways", 64'(rsp_way), 64'd6);
        do_op(FL, 12'h020, 1'b1, 32'hA000_0008);
        chk("R2 exclusive fill uses dynamic tag-only way", 64'(rsp_way), 64'd2);
        chk("R2 dynamic tag-only way has no data", 64'(rsp_present), 64'd0);

        // R2: request 15, clamped to 13; set0 way4 holds dirty 0x004
        set_dis(4'd15, n, wa, wd, r0);
        chk("R10 one writeback on 2->13", 64'(n), 64'd1);
        chk("R10 flushed address way4", 64'(wa), 64'h004);
        chk("R10 flushed data way4", 64'(wd), 64'hB000_0001);
        do_op(LK, 12'h020, 1'b0, 32'h0);
        chk("R10 older tag-only entry kept", 64'(rsp_hit), 64'd1);

        // set 1: only way 15 carries data
        do_op(FL, 12'h079, 1'b0, 32'hC000_0030);
        chk("R2 clamp keeps way15 as data", 64'(rsp_way), 64'd15);
        chk("R2 clamp way15 present", 64'(rsp_present), 64'd1);
        do_op(WB, 12'h079, 1'b0, 32'hD000_0030);
        chk("R6 writeback into way15", 64'(rsp_way), 64'd15);
        do_op(FL, 12'h07D, 1'b0, 32'hC000_0031);
        chk("R4 shared fallback to tag-only", 64'(rsp_way), 64'd0);
        chk("R4 shared fallback not present", 64'(rsp_present), 64'd0);
        do_op(FL, 12'h081, 1'b1, 32'hC000_0032);
        chk("R3 exclusive next tag-only", 64'(rsp_way), 64'd1);
        do_op(WB, 12'h081, 1'b0, 32'hD000_0032);
        chk("R7 move with eviction way", 64'(rsp_way), 64'd15);
        chk("R8 dirty victim written back", 64'(mem_wb_valid), 64'd1);
        chk("R8 victim address", 64'(mem_wb_addr), 64'h079);
        chk("R8 victim data", 64'(mem_wb_data), 64'hD000_0030);
        do_op(LK, 12'h079, 1'b0, 32'h0);
        chk("R8 victim no longer held", 64'(rsp_hit), 64'd0);

        // set 2: fill all 15 tag-only ways, then force a clean eviction
        for (int i = 0; i < 15; i++) begin
            do_op(FL, 12'((40 + i) * 4 + 2), 1'b1, 32'(i));
            chk($sformatf("R3 exclusive fill %0d way", i), 64'(rsp_way), 64'(i));
        end
        do_op(FL, 12'h0F2, 1'b1, 32'hE000_0060);
        chk("R3 full tag-only goes to data", 64'(rsp_way), 64'd15);
        do_op(FL, 12'h0F6, 1'b1, 32'hE000_0061);
        chk("R8 clean eviction way", 64'(rsp_way), 64'd15);
        chk("R8 clean eviction silent", 64'(mem_wb_valid), 64'd0);
        do_op(LK, 12'h0F2, 1'b0, 32'h0);
        chk("R8 clean victim gone", 64'(rsp_hit), 64'd0);

        // R10: decrease 13 -> 12 re-enables way 14 (set2 tag 54 there)
        set_dis(4'd12, n, wa, wd, r0);
        chk("R10 no writeback on decrease", 64'(n), 64'd0);
        do_op(LK, 12'h0DA, 1'b0, 32'h0);
        chk("R10 re-enabled way invalidated", 64'(rsp_hit), 64'd0);

        // R11: set 3, data ways 14 and 15
        do_op(FL, 12'h11B, 1'b0, 32'hF000_0070);
        chk("R11 first data fill way", 64'(rsp_way), 64'd14);
        do_op(FL, 12'h11F, 1'b0, 32'hF000_0071);
        chk("R11 second data fill way", 64'(rsp_way), 64'd15);
        do_op(LK, 12'h11B, 1'b0, 32'h0);
        do_op(FL, 12'h127, 1'b1, 32'hF000_0073);
        do_op(WB, 12'h127, 1'b0, 32'hF100_0073);
        chk("R11 LRU data way taken", 64'(rsp_way), 64'd15);
        chk("R8 clean LRU victim silent", 64'(mem_wb_valid), 64'd0);
        do_op(LK, 12'h11F, 1'b0, 32'h0);
        chk("R11 LRU block evicted", 64'(rsp_hit), 64'd0);
        do_op(LK, 12'h11B, 1'b0, 32'h0);
        chk("R11 recent block kept", 64'(rsp_way), 64'd14);
        chk("R11 recent block data", 64'(rsp_data), 64'hF000_0070);

        // R1: reset clears everything
        set_dis(4'd0, n, wa, wd, r0);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #2;
        rst = 1'b0;
        chk("R1 ready after second reset", 64'(req_ready), 64'd1);
        do_op(LK, 12'h11B, 1'b0, 32'h0);
        chk("R1 block gone after reset", 64'(rsp_hit), 64'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule